// File: doc/BRIEF.md
# Receive Frame Buffer with Per-Entry Status

This block is the buffering stage behind a serial receiver's shift register. Each completed frame holds up to nine data bits, a framing-error indication and a parity-error indication. The frame goes into a two-entry circular queue, and its status flags and ninth bit are stored in the same slot. A host first inspects the status outputs, which always describe the oldest unread frame. It then issues a data read. The read returns the low data bits and retires that slot, so the status of that frame is gone once it has been read.

When both queue slots are occupied, a newly completed frame is not discarded. It stays parked in a holding register that models the shift register. It moves into the queue on the clock edge at which a slot frees up. A frame is lost only when a new start bit arrives while the queue is full and the holding register is still occupied. In that case the parked frame is dropped and an overrun mark is attached to the next frame that enters the queue. Turning the receiver off empties the queue and the holding register.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, `rx_done`, `rd_dout` and all four head status outputs are 0.
- R2: Frames leave in arrival order, and `rx_done` is 1 exactly while at least one queue slot is occupied.
- R3: `head_bit9` (data bit 8), `head_ferr` and `head_perr` show the oldest unread frame. After that frame is read they show the next frame, and they are 0 when the queue is empty.
- R4: A `rd_req` pulse on a non-empty queue loads data bits 7..0 of the oldest frame into `rd_dout` at that clock edge and retires the frame.
- R5: A `rd_req` pulse on an empty queue leaves `rd_dout`, `rx_done` and the status outputs unchanged.
- R6: A frame completed while both slots are occupied is held, not discarded. It enters the queue at the same edge that retires a frame, so it is readable third in order.
- R7: A `start_det` pulse while both slots are occupied and a frame is held drops the held frame. The next frame written into the queue carries `head_ovr` = 1.
- R8: A `start_det` pulse while a slot is free, or while no frame is held, causes no overrun, and no frame is lost.
- R9: The overrun mark belongs to one entry only. It disappears when that entry is read, and later entries show `head_ovr` = 0.
- R10: While `rx_en` is 0 the queue and the holding register are emptied and `frm_valid` is ignored. `rd_dout` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes all stored frames |
| frm_valid | input | 1 | One-cycle pulse: a frame has completed in the shift register |
| frm_data | input | DATA_W | Completed frame data, bit DATA_W-1 is the ninth bit |
| frm_ferr | input | 1 | Framing error of the completed frame |
| frm_perr | input | 1 | Parity error of the completed frame |
| start_det | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_req | input | 1 | Host data read strobe |
| rd_dout | output | DATA_W-1 | Data returned by the last read of a non-empty queue |
| rx_done | output | 1 | Queue holds at least one unread frame |
| head_bit9 | output | 1 | Ninth bit of the oldest unread frame |
| head_ferr | output | 1 | Framing error of the oldest unread frame |
| head_perr | output | 1 | Parity error of the oldest unread frame |
| head_ovr | output | 1 | Overrun mark of the oldest unread frame |

## Verification
Every input pulse is registered once. A frame, a read, a start bit or a disable therefore shows its effect at the outputs one clock edge later. That includes the held frame moving into the slot freed by a read. The bench drives each stimulus on a falling edge and samples all outputs on the next falling edge, half a period after the single rising edge that registers the pulse. Each table row thus checks the state exactly one register stage after its own stimulus.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    // Status bits stored beside the data in every queue entry.
    // ovr is the least significant field and sits directly above the data bits.
    typedef struct packed {
        logic ferr;
        logic perr;
        logic ovr;
    } rxb_flags_t;

    localparam int RXB_FLAG_W = $bits(rxb_flags_t);
endpackage

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
    parameter int ENT_W = 12,
    parameter int DEPTH = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int ENT_W = DATA_W + rxbuf_pkg::RXB_FLAG_W,
    localparam int OVR_B = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frm_valid,
    input  logic [ENT_W-1:0]  new_ent,
    input  logic              start_det,
    input  logic              rd_req,
    input  logic [ENT_W-1:0]  head_ent,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [ENT_W-1:0]  mem_wdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [CW-1:0]     fill,
    output logic [DATA_W-2:0] dout
);
    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     fill;
        logic              held_vld;
        logic [ENT_W-1:0]  held_ent;
        logic              ovr_pend;
        logic [DATA_W-2:0] dout;
    } st_t;

    st_t q, d;
    logic pop, free, ovr_now;
    logic [ENT_W-1:0] wr_src;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        wr_src    = '0;
        pop       = 1'b0;
        free      = 1'b0;
        ovr_now   = 1'b0;
        if (!rx_en) begin
            d.wptr     = '0;
            d.rptr     = '0;
            d.fill     = '0;
            d.held_vld = 1'b0;
            d.ovr_pend = 1'b0;
        end else begin
            pop = rd_req && (q.fill != '0);
            if (pop) begin
                d.dout = head_ent[DATA_W-2:0];
                d.rptr = ptr_inc(q.rptr);
            end
            free = (q.fill < CW'(DEPTH)) || pop;
            // Held frame is older than anything new, so it goes first.
            if (q.held_vld && free) begin
                mem_we     = 1'b1;
                wr_src     = q.held_ent;
                d.held_vld = 1'b0;
            end else if (q.held_vld && start_det) begin
                ovr_now    = 1'b1;
                d.held_vld = 1'b0;
            end
            if (frm_valid) begin
                if (free && !q.held_vld) begin
                    mem_we = 1'b1;
                    wr_src = new_ent;
                end else begin
                    if (d.held_vld) begin
                        ovr_now = 1'b1;
                    end
                    d.held_vld = 1'b1;
                    d.held_ent = new_ent;
                end
            end
            if (mem_we) begin
                mem_wdata        = wr_src;
                mem_wdata[OVR_B] = q.ovr_pend;
                d.wptr           = ptr_inc(q.wptr);
                d.ovr_pend       = 1'b0;
            end
            if (ovr_now) begin
                d.ovr_pend = 1'b1;
            end
            d.fill = q.fill + CW'(mem_we) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_waddr = q.wptr;
    assign mem_raddr = q.rptr;
    assign fill      = q.fill;
    assign dout      = q.dout;
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int ENT_W = DATA_W + rxbuf_pkg::RXB_FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_ferr,
    input  logic              frm_perr,
    input  logic              start_det,
    input  logic              rd_req,
    output logic [DATA_W-2:0] rd_dout,
    output logic              rx_done,
    output logic              head_bit9,
    output logic              head_ferr,
    output logic              head_perr,
    output logic              head_ovr
);
    import rxbuf_pkg::*;

    logic [ENT_W-1:0] new_ent, head_ent, mem_wdata;
    logic [AW-1:0]    mem_waddr, mem_raddr;
    logic             mem_we;
    logic [CW-1:0]    fill;
    rxb_flags_t       in_flags, head_flags;

    assign in_flags = '{ferr: frm_ferr, perr: frm_perr, ovr: 1'b0};
    assign new_ent  = {in_flags, frm_data};

    rxbuf_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
        .new_ent(new_ent), .start_det(start_det), .rd_req(rd_req),
        .head_ent(head_ent), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .fill(fill),
        .dout(rd_dout)
    );

    rxbuf_mem #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(head_ent)
    );

    assign rx_done    = (fill != '0);
    assign head_flags = rx_done ? rxb_flags_t'(head_ent[ENT_W-1:DATA_W]) : '0;
    assign head_bit9  = rx_done & head_ent[DATA_W-1];
    assign head_ferr  = head_flags.ferr;
    assign head_perr  = head_flags.perr;
    assign head_ovr   = head_flags.ovr;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int ENT_W = DATA_W + rxbuf_pkg::RXB_FLAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              frm_valid,
    input logic              rd_req,
    input logic              rx_done,
    input logic [DATA_W-2:0] rd_dout,
    input logic [ENT_W-1:0]  head_ent,
    input logic [CW-1:0]     fill
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_done); // R10

    AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rx_done) |=> $stable(rd_dout)); // R5

    AST_READ_RETURNS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rx_done && rx_en) |=> (rd_dout == $past(head_ent[DATA_W-2:0]))); // R4

    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && rx_en && !rx_done) |=> rx_done); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R6
endmodule

bind rx_frame_buffer rxbuf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
    .rd_req(rd_req), .rx_done(rx_done), .rd_dout(rd_dout),
    .head_ent(head_ent), .fill(fill)
);

// File: tb/sim_rx_frame_buffer.sv
module sim_rx_frame_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       frm_valid = 1'b0;
    logic [8:0] frm_data = '0;
    logic       frm_ferr = 1'b0;
    logic       frm_perr = 1'b0;
    logic       start_det = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_dout;
    logic       rx_done, head_bit9, head_ferr, head_perr, head_ovr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rx_frame_buffer u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
        .frm_data(frm_data), .frm_ferr(frm_ferr), .frm_perr(frm_perr),
        .start_det(start_det), .rd_req(rd_req), .rd_dout(rd_dout),
        .rx_done(rx_done), .head_bit9(head_bit9), .head_ferr(head_ferr),
        .head_perr(head_perr), .head_ovr(head_ovr)
    );

    // op: 0 idle, 1 frame, 2 read, 3 start bit
    typedef struct packed {
        logic [1:0] op;
        logic [8:0] d;
        logic       fe;
        logic       pe;
        logic       x_done;
        logic [7:0] x_dout;
        logic       x_b9;
        logic       x_fe;
        logic       x_pe;
        logic       x_ov;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 9'h1A5, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
        '{2'd1, 9'h03C, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        '{2'd1, 9'h155, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{2'd1, 9'h011, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd1, 9'h022, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{2'd1, 9'h033, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{2'd3, 9'h000, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{2'd1, 9'h044, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},  // 0x033 lost
        '{2'd1, 9'h066, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{2'd3, 9'h000, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{2'd1, 9'h077, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd3, 9'h000, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd1, 9'h088, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{2'd2, 9'h000, 1'b0, 1'b0, 1'b0, 8'h88, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}
    };

    function automatic logic [12:0] outs();
        return {rx_done, rd_dout, head_bit9, head_ferr, head_perr, head_ovr};
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got done=%b dout=%h b9/fe/pe/ov=%b expected done=%b dout=%h b9/fe/pe/ov=%b",
                     req, act[12], act[11:4], act[3:0], exp[12], exp[11:4], exp[3:0]);
        end
    endtask

    // Called on a falling edge; drives one stimulus cycle and returns on the next falling edge.
    task automatic step(input logic [1:0] op, input logic [8:0] d, input logic fe, input logic pe);
        frm_valid = (op == 2'd1);
        rd_req    = (op == 2'd2);
        start_det = (op == 2'd3);
        frm_data  = d;
        frm_ferr  = fe;
        frm_perr  = pe;
        @(negedge clk);
        frm_valid = 1'b0;
        rd_req    = 1'b0;
        start_det = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 13'h0);
        rx_en = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].op, TBL[i].d, TBL[i].fe, TBL[i].pe);
            check($sformatf("R%0d", TBL[i].req), outs(),
                  {TBL[i].x_done, TBL[i].x_dout, TBL[i].x_b9, TBL[i].x_fe, TBL[i].x_pe, TBL[i].x_ov});
        end

        // R10: flush of queue and held frame, frames ignored while disabled
        step(2'd1, 9'h0A1, 1'b1, 1'b0);
        step(2'd1, 9'h0A2, 1'b0, 1'b0);
        step(2'd1, 9'h0A3, 1'b0, 1'b0);
        rx_en = 1'b0;
        step(2'd0, 9'h000, 1'b0, 1'b0);
        check("R10", outs(), {1'b0, 8'h88, 4'b0000});
        step(2'd1, 9'h0B1, 1'b0, 1'b0);
        check("R10", outs(), {1'b0, 8'h88, 4'b0000});
        rx_en = 1'b1;
        step(2'd2, 9'h000, 1'b0, 1'b0);
        check("R5", outs(), {1'b0, 8'h88, 4'b0000});
        step(2'd1, 9'h1AB, 1'b0, 1'b1);
        check("R3", outs(), {1'b1, 8'h88, 4'b1010});
        step(2'd2, 9'h000, 1'b0, 1'b0);
        check("R10", outs(), {1'b0, 8'hAB, 4'b0000});
        step(2'd0, 9'h000, 1'b0, 1'b0);
        check("R10", outs(), {1'b0, 8'hAB, 4'b0000});

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule